// File: doc/BRIEF.md
# Clock Source Select and Divider Tree

This block turns a set of clock-enable tick inputs into the system clock-enable pulses of a chip. A reference source is chosen from a high-frequency crystal tick, a 32 kHz low-frequency tick, or a tick from an external frequency-multiplier source that runs at 1024 times the low-frequency rate. The main clock is then either that reference or the tick of an external PLL. Four programmable integer dividers derive the processor, high-speed-peripheral, bus and peripheral enables. The peripheral divider is fed by the bus divider's output, not by the main clock.

All clocks are represented as single-cycle enables of one fast system clock. Each divider counts input ticks and emits one pulse for each group of (field + 1) ticks. A new divider value is picked up at the divider's next output pulse, so a count already in progress finishes with the old value. Alongside the pulses, the block reports the nominal frequency of every derived clock in hertz. These values are computed from the crystal and low-frequency rates, which are parameters, and from a PLL frequency supplied on an input.

Top module: `ccm_clk_tree`

## Requirements
- R1: When `refSel` is not 2, the reference is the crystal tick `hfTick`, and `refFreq` equals the XTAL_HZ parameter (default 26000000).
- R2: When `refSel` equals 2 and `fpmEn` is 1, the reference is `lfTick` with `refFreq` = LF_HZ (32768) if `fpmFactor` is 0. If `fpmFactor` is 1, the reference is `fpmTick` with `refFreq` = LF_HZ*1024.
- R3: When `refSel` equals 2 and `fpmEn` is 0, the reference produces no ticks and `refFreq` is 0.
- R4: The main tick is the reference when `pllBypass` is 1 or `pllEn` is 0. Otherwise it is `pllTick`, and the main frequency is `pllFreq`.
- R5: `mcuEn`, `hspEn` and `hclkEn` each divide the main tick by (field + 1). The fields are 3 bits wide and sit in `divCfg`: processor at [2:0], bus at [5:3], high-speed peripheral at [13:11]. All other `divCfg` bits have no effect.
- R6: `ipgEn` divides the `hclkEn` pulses by (`divCfg[7:6]` + 1).
- R7: Each divider output is a one-cycle pulse, registered one cycle after the input tick that causes it. After reset, the first input tick gives a pulse, and then every (field + 1)th tick does, so T ticks give ceil(T/(field+1)) pulses.
- R8: A changed divider field takes effect only at that divider's next output pulse.
- R9: `clk32En` equals `lfTick` in the same cycle, whatever the mode inputs are.
- R10: `mcuFreq`, `hspFreq` and `hclkFreq` equal the main frequency divided (truncating) by their field + 1. `ipgFreq` equals `hclkFreq` divided by (`divCfg[7:6]` + 1).
- R11: While `rstN` is low, all four divided enables are 0 and every divider restarts from its first-tick state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hfTick | input | 1 | Crystal clock enable tick |
| lfTick | input | 1 | 32 kHz clock enable tick |
| fpmTick | input | 1 | Frequency-multiplier (x1024) clock enable tick |
| pllTick | input | 1 | PLL output clock enable tick |
| refSel | input | 2 | Reference select; value 2 picks the low-frequency path |
| fpmEn | input | 1 | Enables the low-frequency reference path |
| fpmFactor | input | 1 | Chooses the x1024 multiplier tick over the raw 32 kHz tick |
| pllBypass | input | 1 | Forces the main clock to the reference |
| pllEn | input | 1 | PLL enable; 0 forces the main clock to the reference |
| divCfg | input | 16 | Divider fields (see R5, R6) |
| pllFreq | input | 32 | PLL output frequency in Hz |
| mcuEn | output | 1 | Processor clock enable |
| hspEn | output | 1 | High-speed-peripheral clock enable |
| hclkEn | output | 1 | Bus clock enable |
| ipgEn | output | 1 | Peripheral clock enable |
| clk32En | output | 1 | 32 kHz clock enable pass-through |
| refFreq | output | 32 | Reference frequency in Hz |
| mcuFreq | output | 32 | Processor clock frequency in Hz |
| hspFreq | output | 32 | High-speed-peripheral frequency in Hz |
| hclkFreq | output | 32 | Bus clock frequency in Hz |
| ipgFreq | output | 32 | Peripheral clock frequency in Hz |

## Verification
The hardest case to reach is a divider field that changes while a count is part-way through. The effect only shows up in how many pulses come out over the following ticks. The stimulus reaches it with a directed sequence: reset, one tick to load a long count, a switch to divide-by-one, and then a known number of ticks. The expected pulse totals with and without the deferred reload differ. Random trials then cover every source selection together with a count of each tick input, and the bench sums the selected source's ticks to predict each divider's pulse count.

// File: rtl/ccm_pkg.sv
package ccm_pkg;
  localparam int DIV_W  = 3;
  localparam int IPG_W  = 2;
  localparam int CFG_W  = 16;
  localparam int FREQ_W = 32;
  localparam int NDIV   = 3;

  // Field base positions inside divCfg (order of dividers: mcu, bus, hsp)
  localparam int MCU_LSB = 0;
  localparam int BUS_LSB = 3;
  localparam int IPG_LSB = 6;
  localparam int HSP_LSB = 11;

  localparam logic [1:0] REF_SEL_LOW = 2'd2;

  typedef struct packed {
    logic refTick;
    logic mainTick;
  } selStrobe_t;
endpackage

// File: rtl/ccm_tick_div.sv
module ccm_tick_div #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         tickIn,
  input  logic [W-1:0] ratio,
  output logic         pulseOut
);
  logic [W-1:0] cnt;

  // Reload happens only on an output pulse, so a new ratio waits for it.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt      <= '0;
      pulseOut <= 1'b0;
    end else begin
      pulseOut <= 1'b0;
      if (tickIn) begin
        if (cnt == '0) begin
          pulseOut <= 1'b1;
          cnt      <= ratio;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/ccm_src_ctrl.sv
module ccm_src_ctrl
  import ccm_pkg::*;
#(
  parameter int unsigned XTAL_HZ  = 26000000,
  parameter int unsigned LF_HZ    = 32768,
  parameter int unsigned FPM_MULT = 1024
) (
  input  logic              hfTick,
  input  logic              lfTick,
  input  logic              fpmTick,
  input  logic              pllTick,
  input  logic [1:0]        refSel,
  input  logic              fpmEn,
  input  logic              fpmFactor,
  input  logic              pllBypass,
  input  logic              pllEn,
  input  logic [FREQ_W-1:0] pllFreq,
  output selStrobe_t        strobe,
  output logic [FREQ_W-1:0] refFreq,
  output logic [FREQ_W-1:0] mainFreq
);
  localparam logic [FREQ_W-1:0] XTAL_F = FREQ_W'(XTAL_HZ);
  localparam logic [FREQ_W-1:0] LF_F   = FREQ_W'(LF_HZ);
  localparam logic [FREQ_W-1:0] FPM_F  = FREQ_W'(LF_HZ * FPM_MULT);

  logic lowPath;
  logic useRef;

  assign lowPath = (refSel == REF_SEL_LOW);
  assign useRef  = pllBypass || !pllEn;

  always_comb begin
    if (!lowPath) begin
      strobe.refTick = hfTick;
      refFreq        = XTAL_F;
    end else if (!fpmEn) begin
      strobe.refTick = 1'b0;
      refFreq        = '0;
    end else if (fpmFactor) begin
      strobe.refTick = fpmTick;
      refFreq        = FPM_F;
    end else begin
      strobe.refTick = lfTick;
      refFreq        = LF_F;
    end
    strobe.mainTick = useRef ? strobe.refTick : pllTick;
    mainFreq        = useRef ? refFreq : pllFreq;
  end
endmodule

// File: rtl/ccm_div_path.sv
module ccm_div_path
  import ccm_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  selStrobe_t        strobe,
  input  logic [CFG_W-1:0]  divCfg,
  input  logic [FREQ_W-1:0] mainFreq,
  output logic              mcuEn,
  output logic              hspEn,
  output logic              hclkEn,
  output logic              ipgEn,
  output logic [FREQ_W-1:0] mcuFreq,
  output logic [FREQ_W-1:0] hspFreq,
  output logic [FREQ_W-1:0] hclkFreq,
  output logic [FREQ_W-1:0] ipgFreq
);
  localparam int LSBS [NDIV] = '{MCU_LSB, BUS_LSB, HSP_LSB};

  logic [NDIV-1:0]             pulses;
  logic [NDIV-1:0][FREQ_W-1:0] freqs;
  logic [IPG_W-1:0]            ipgRatio;

  for (genvar g = 0; g < NDIV; g++) begin : gMain
    logic [DIV_W-1:0] ratio;
    assign ratio = divCfg[LSBS[g] +: DIV_W];
    ccm_tick_div #(.W(DIV_W)) u_div (
      .clk     (clk),
      .rstN    (rstN),
      .tickIn  (strobe.mainTick),
      .ratio   (ratio),
      .pulseOut(pulses[g])
    );
    assign freqs[g] = mainFreq / (FREQ_W'(ratio) + FREQ_W'(1));
  end

  assign ipgRatio = divCfg[IPG_LSB +: IPG_W];

  // Peripheral divider cascades from the bus divider output.
  ccm_tick_div #(.W(IPG_W)) u_ipgDiv (
    .clk     (clk),
    .rstN    (rstN),
    .tickIn  (pulses[1]),
    .ratio   (ipgRatio),
    .pulseOut(ipgEn)
  );

  assign mcuEn    = pulses[0];
  assign hclkEn   = pulses[1];
  assign hspEn    = pulses[2];
  assign mcuFreq  = freqs[0];
  assign hclkFreq = freqs[1];
  assign hspFreq  = freqs[2];
  assign ipgFreq  = freqs[1] / (FREQ_W'(ipgRatio) + FREQ_W'(1));
endmodule

// File: rtl/ccm_clk_tree.sv
module ccm_clk_tree
  import ccm_pkg::*;
#(
  parameter int unsigned XTAL_HZ  = 26000000,
  parameter int unsigned LF_HZ    = 32768,
  parameter int unsigned FPM_MULT = 1024
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hfTick,
  input  logic              lfTick,
  input  logic              fpmTick,
  input  logic              pllTick,
  input  logic [1:0]        refSel,
  input  logic              fpmEn,
  input  logic              fpmFactor,
  input  logic              pllBypass,
  input  logic              pllEn,
  input  logic [CFG_W-1:0]  divCfg,
  input  logic [FREQ_W-1:0] pllFreq,
  output logic              mcuEn,
  output logic              hspEn,
  output logic              hclkEn,
  output logic              ipgEn,
  output logic              clk32En,
  output logic [FREQ_W-1:0] refFreq,
  output logic [FREQ_W-1:0] mcuFreq,
  output logic [FREQ_W-1:0] hspFreq,
  output logic [FREQ_W-1:0] hclkFreq,
  output logic [FREQ_W-1:0] ipgFreq
);
  selStrobe_t        strobe;
  logic [FREQ_W-1:0] mainFreq;

  ccm_src_ctrl #(.XTAL_HZ(XTAL_HZ), .LF_HZ(LF_HZ), .FPM_MULT(FPM_MULT)) u_ctrl (
    .hfTick   (hfTick),
    .lfTick   (lfTick),
    .fpmTick  (fpmTick),
    .pllTick  (pllTick),
    .refSel   (refSel),
    .fpmEn    (fpmEn),
    .fpmFactor(fpmFactor),
    .pllBypass(pllBypass),
    .pllEn    (pllEn),
    .pllFreq  (pllFreq),
    .strobe   (strobe),
    .refFreq  (refFreq),
    .mainFreq (mainFreq)
  );

  ccm_div_path u_path (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .divCfg  (divCfg),
    .mainFreq(mainFreq),
    .mcuEn   (mcuEn),
    .hspEn   (hspEn),
    .hclkEn  (hclkEn),
    .ipgEn   (ipgEn),
    .mcuFreq (mcuFreq),
    .hspFreq (hspFreq),
    .hclkFreq(hclkFreq),
    .ipgFreq (ipgFreq)
  );

  assign clk32En = lfTick;
endmodule

// File: rtl/ccm_clk_tree_chk.sv
module ccm_clk_tree_chk (
  input logic        clk,
  input logic        rstN,
  input logic        hfTick,
  input logic        pllTick,
  input logic [1:0]  refSel,
  input logic        fpmEn,
  input logic        pllBypass,
  input logic        pllEn,
  input logic        mcuEn,
  input logic        hspEn,
  input logic        hclkEn,
  input logic        ipgEn,
  input logic [31:0] refFreq,
  input logic [31:0] hclkFreq,
  input logic [31:0] ipgFreq
);
  // R1
  xtal_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(refSel != 2'd2 && (pllBypass || !pllEn) && !hfTick) |-> !mcuEn && !hspEn && !hclkEn);

  // R3
  ref_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(refSel == 2'd2 && !fpmEn && (pllBypass || !pllEn)) |-> !mcuEn && !hspEn && !hclkEn);

  // R3
  ref_off_freq_chk: assert property (@(posedge clk) disable iff (!rstN)
    (refSel == 2'd2 && !fpmEn) |-> refFreq == 32'd0);

  // R4
  pll_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(pllEn && !pllBypass && !pllTick) |-> !mcuEn && !hspEn && !hclkEn);

  // R6
  ipg_follows_bus_chk: assert property (@(posedge clk) disable iff (!rstN)
    ipgEn |-> $past(hclkEn));

  // R10
  ipg_freq_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    ipgFreq <= hclkFreq);
endmodule

bind ccm_clk_tree ccm_clk_tree_chk i_chk (.*);

// File: tb/test_ccm_clk_tree.sv
module test_ccm_clk_tree;
  localparam int CLK_PERIOD = 10;
  localparam int unsigned XTAL = 26000000;
  localparam int unsigned LFHZ = 32768;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hfTick = 0, lfTick = 0, fpmTick = 0, pllTick = 0;
  logic [1:0] refSel = 0;
  logic fpmEn = 0, fpmFactor = 0, pllBypass = 0, pllEn = 0;
  logic [15:0] divCfg = 0;
  logic [31:0] pllFreq = 32'd400000000;
  logic mcuEn, hspEn, hclkEn, ipgEn, clk32En;
  logic [31:0] refFreq, mcuFreq, hspFreq, hclkFreq, ipgFreq;

  int checks = 0;
  int errors = 0;
  int nHf, nLf, nFpm, nPll, nMcu, nHsp, nHclk, nIpg, badClk32;

  always #(CLK_PERIOD/2) clk = ~clk;

  ccm_clk_tree i_ccm_clk_tree (.*);

  task automatic check(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint ceilDiv(longint t, longint d);
    return (t + d - 1) / d;
  endfunction

  function automatic longint expRefFreq();
    if (refSel != 2'd2) return XTAL;
    if (!fpmEn) return 0;
    return fpmFactor ? longint'(LFHZ) * 1024 : LFHZ;
  endfunction

  function automatic longint expMainTicks();
    if (pllEn && !pllBypass) return nPll;
    if (refSel != 2'd2) return nHf;
    if (!fpmEn) return 0;
    return fpmFactor ? nFpm : nLf;
  endfunction

  // Sample on the falling edge, then drive the next inputs there.
  always @(negedge clk) begin
    if (mcuEn) nMcu++;
    if (hspEn) nHsp++;
    if (hclkEn) nHclk++;
    if (ipgEn) nIpg++;
    if (clk32En !== lfTick) badClk32++;
  end

  task automatic clearCounts();
    nHf = 0; nLf = 0; nFpm = 0; nPll = 0;
    nMcu = 0; nHsp = 0; nHclk = 0; nIpg = 0; badClk32 = 0;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    hfTick = 0; lfTick = 0; fpmTick = 0; pllTick = 0;
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b1;
    clearCounts();
  endtask

  task automatic randTicks(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      hfTick  = $urandom_range(0, 1);
      lfTick  = $urandom_range(0, 1);
      fpmTick = $urandom_range(0, 1);
      pllTick = $urandom_range(0, 1);
      nHf += hfTick; nLf += lfTick; nFpm += fpmTick; nPll += pllTick;
    end
    @(negedge clk);
    hfTick = 0; lfTick = 0; fpmTick = 0; pllTick = 0;
    repeat (3) @(negedge clk);
  endtask

  task automatic hfPulses(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); hfTick = 1'b1;
      @(negedge clk); hfTick = 1'b0;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic checkFreqs(string tag);
    longint m, h;
    m = (pllEn && !pllBypass) ? longint'(pllFreq) : expRefFreq();
    h = m / (divCfg[5:3] + 1);
    check({tag, " R1 R2 R3 refFreq"}, refFreq, expRefFreq());
    check({tag, " R10 mcuFreq"}, mcuFreq, m / (divCfg[2:0] + 1));
    check({tag, " R10 hspFreq"}, hspFreq, m / (divCfg[13:11] + 1));
    check({tag, " R10 hclkFreq"}, hclkFreq, h);
    check({tag, " R10 ipgFreq"}, ipgFreq, h / (divCfg[7:6] + 1));
  endtask

  task automatic checkCounts(string tag);
    longint mt, ht;
    mt = expMainTicks();
    ht = ceilDiv(mt, divCfg[5:3] + 1);
    check({tag, " R4 R5 R7 mcu pulses"}, nMcu, ceilDiv(mt, divCfg[2:0] + 1));
    check({tag, " R5 R7 hsp pulses"}, nHsp, ceilDiv(mt, divCfg[13:11] + 1));
    check({tag, " R5 R7 hclk pulses"}, nHclk, ht);
    check({tag, " R6 ipg pulses"}, nIpg, ceilDiv(ht, divCfg[7:6] + 1));
    check({tag, " R9 clk32 mismatches"}, badClk32, 0);
  endtask

  initial begin
    void'($urandom(32'd20240611));

    // R11: outputs stay low in reset even with ticks present
    rstN = 1'b0;
    refSel = 0; pllEn = 0; divCfg = 0;
    clearCounts();
    repeat (4) begin
      @(negedge clk);
      hfTick = 1; pllTick = 1; lfTick = 1;
    end
    @(negedge clk);
    check("R11 pulses during reset", nMcu + nHsp + nHclk + nIpg, 0);
    hfTick = 0; pllTick = 0; lfTick = 0;

    // R3 directed: low path selected but disabled
    refSel = 2'd2; fpmEn = 0; pllEn = 0; pllBypass = 0; divCfg = 0;
    doReset();
    randTicks(40);
    check("R3 mcu pulses with ref off", nMcu, 0);
    check("R3 refFreq with ref off", refFreq, 0);

    // R2 directed: both low-frequency variants
    for (int f = 0; f < 2; f++) begin
      refSel = 2'd2; fpmEn = 1; fpmFactor = f[0]; pllEn = 1; pllBypass = 1;
      divCfg = 16'h0000;
      doReset();
      randTicks(50);
      checkCounts("R2 directed");
      checkFreqs("R2 directed");
    end

    // R8: field change deferred to next pulse
    refSel = 0; pllEn = 0; pllBypass = 0; divCfg = 16'h0003;
    doReset();
    hfPulses(1);
    check("R8 first pulse", nMcu, 1);
    divCfg = 16'h0000;
    hfPulses(3);
    check("R8 old count still running", nMcu, 1);
    hfPulses(3);
    check("R8 new ratio after reload", nMcu, 4);

    // R5: bits outside the fields have no effect
    refSel = 1; pllEn = 0; divCfg = 16'hC700 | 16'h0812;
    doReset();
    randTicks(60);
    checkCounts("R5 unused bits");

    // Random trials across modes and ratios
    for (int t = 0; t < 60; t++) begin
      refSel    = 2'($urandom_range(0, 3));
      fpmEn     = $urandom_range(0, 1);
      fpmFactor = $urandom_range(0, 1);
      pllBypass = $urandom_range(0, 1);
      pllEn     = $urandom_range(0, 1);
      divCfg    = 16'($urandom);
      pllFreq   = $urandom_range(1000000, 600000000);
      doReset();
      randTicks(80);
      checkCounts("random");
      checkFreqs("random");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule